// File: doc/BRIEF.md
# Periodic Simulation Step Sequencer

This block paces a fixed-latency compute engine inside a hardware-in-the-loop loop. A programmable period timer produces step ticks. On a tick, the sequencer pulses a start strobe to the engine, but only if the host has acknowledged the previous step. When the engine signals completion, the sequencer copies the engine's output words, one per clock, into a dual-port result buffer that the host can read. Only after the last word has been written does it raise a level interrupt.

The host reads the results and writes the next inputs to the engine. It then writes the acknowledge register. That write is the only event that clears the interrupt and allows the next step to launch. If a tick arrives while results are still waiting for the host, the tick is counted as skipped. If a tick arrives while the engine is still busy, it is dropped and a sticky overrun flag is set.

Data words are 32-bit signed fixed point with 16 fraction bits. The block moves them unchanged.

Top module: `step_pacer`

## Requirements
- R1: While enabled (CTRL address 0, bit 0), the timer ticks once every PERIOD cycles (PERIOD register at address 1, reset value 300; values 0 and 1 tick every cycle). When the host acknowledges promptly, consecutive start pulses are exactly PERIOD cycles apart.
- R2: A tick seen in IDLE produces a start pulse that is exactly one cycle wide, and the state becomes RUN.
- R3: A done seen in RUN causes output word i to be written to buffer address i, one word per clock from address 0 upwards. The interrupt rises in the cycle after the last write, which is N_WORDS+1 cycles after the cycle in which done was driven.
- R4: The interrupt stays high until a write to the ACK register (address 3, any data). An ACK written while no interrupt is pending has no effect.
- R5: A tick that arrives while the interrupt is pending does not launch a step. It increments the skip counter (address 4), which saturates at 65535. This includes a tick in the same cycle as the ACK write, which returns the state to IDLE; the step then starts on the following tick.
- R6: A tick that arrives in RUN or COPY sets the sticky overrun flag (STATUS bit 2) and is dropped, with no extra start.
- R7: Clearing the enable bit stops new ticks. A step already in progress still completes, including its interrupt and acknowledge, and the block then rests in IDLE.
- R8: STATUS (address 2) reads state in bits [1:0] (IDLE=0, RUN=1, COPY=2, WAIT_ACK=3), overrun in bit 2 and interrupt in bit 3.
- R9: The host buffer read port returns the addressed word one clock after the address is presented.
- R10: After reset the state is IDLE, the interrupt and start are low, the skip count is 0 and the overrun flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| eng_start_o | output | 1 | One-cycle start pulse to the engine |
| eng_done_i | input | 1 | Engine completion pulse |
| eng_data_i | input | N_WORDS*DATA_W | Engine output words, word i at bits [i*DATA_W +: DATA_W] |
| buf_raddr_i | input | AW | Host buffer read address |
| buf_rdata_o | output | DATA_W | Host buffer read data |
| irq_o | output | 1 | Level interrupt, results ready |

## Verification
Two events can fall in the same cycle: the host's acknowledge write and a timer tick that lands while results are still pending. The bench provokes this by setting the period to one, so that a tick occurs on every clock, and then writing ACK after a randomised number of pending cycles. It judges the outcome in two ways. The skip count must grow by exactly the number of edges from re-enable through the ACK edge. The next start must appear exactly one cycle after that ACK edge. The same every-cycle ticking during the following step also exercises overrun: ticks that fall inside RUN and COPY must be dropped without producing an extra start.

// File: rtl/step_pacer_pkg.sv
package step_pacer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_RUN      = 2'd1,
    ST_COPY     = 2'd2,
    ST_WAIT_ACK = 2'd3
  } seq_state_e;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_PERIOD = 3'd1;
  localparam logic [2:0] A_STATUS = 3'd2;
  localparam logic [2:0] A_ACK    = 3'd3;
  localparam logic [2:0] A_SKIP   = 3'd4;
endpackage

// File: rtl/step_timer.sv
module step_timer #(
  parameter int PER_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PER_W-1:0] period_i,
  output logic             tick_o
);
  logic [PER_W-1:0] cnt_q;
  logic             last;

  // >= so a period lowered mid-count wraps at once
  assign last   = (period_i <= PER_W'(1)) || (cnt_q >= period_i - PER_W'(1));
  assign tick_o = en_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!en_i || last) cnt_q <= '0;
    else                  cnt_q <= cnt_q + PER_W'(1);
  end

  a_r1_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o && period_i > PER_W'(1) && $stable(period_i) |=> !tick_o);
  a_r7_no_tick_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);
endmodule

// File: rtl/step_seq_fsm.sv
module step_seq_fsm
  import step_pacer_pkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int CNT_W   = 16,
  localparam int AW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ack_i,
  input  logic             done_i,
  output logic             start_o,
  output seq_state_e       state_o,
  output logic             irq_o,
  output logic             we_o,
  output logic [AW-1:0]    waddr_o,
  output logic [CNT_W-1:0] skip_o,
  output logic             overrun_o
);
  localparam logic [AW-1:0]    LAST_IDX = AW'(N_WORDS - 1);
  localparam logic [CNT_W-1:0] SKIP_MAX = '1;

  seq_state_e       state_q;
  logic [AW-1:0]    idx_q;
  logic             start_q, ovr_q;
  logic [CNT_W-1:0] skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      start_q <= 1'b0;
      skip_q  <= '0;
      ovr_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tick_i) begin
          state_q <= ST_RUN;
          start_q <= 1'b1;
        end
        ST_RUN: if (done_i) begin
          state_q <= ST_COPY;
          idx_q   <= '0;
        end
        ST_COPY: begin
          if (idx_q == LAST_IDX) state_q <= ST_WAIT_ACK;
          else                   idx_q   <= idx_q + AW'(1);
        end
        ST_WAIT_ACK: if (ack_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
      // tick coinciding with ack is still a skip: it saw a pending irq
      if (tick_i && state_q == ST_WAIT_ACK && skip_q != SKIP_MAX)
        skip_q <= skip_q + CNT_W'(1);
      if (tick_i && (state_q == ST_RUN || state_q == ST_COPY))
        ovr_q <= 1'b1;
    end
  end

  assign start_o   = start_q;
  assign state_o   = state_q;
  assign irq_o     = (state_q == ST_WAIT_ACK);
  assign we_o      = (state_q == ST_COPY);
  assign waddr_o   = idx_q;
  assign skip_o    = skip_q;
  assign overrun_o = ovr_q;

  a_r2_start_in_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> state_q == ST_RUN);
  a_r2_start_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);
  a_r3_irq_after_last_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(we_o) && $past(waddr_o) == LAST_IDX);
  a_r3_write_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> int'(waddr_o) < N_WORDS);
  a_r4_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o && !ack_i |=> irq_o);
  a_r5_blocked_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && irq_o |=> !start_o);
  a_r5_skip_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q >= $past(skip_q));
  a_r6_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
endmodule

// File: rtl/step_result_buf.sv
module step_result_buf #(
  parameter int DATA_W  = 32,
  parameter int N_WORDS = 8,
  localparam int AW     = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [N_WORDS];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/step_pacer.sv
module step_pacer
  import step_pacer_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int N_WORDS    = 8,
  parameter int PER_W      = 16,
  parameter int CNT_W      = 16,
  parameter int DEF_PERIOD = 300,
  localparam int AW        = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [2:0]                reg_addr_i,
  input  logic [31:0]               reg_wdata_i,
  output logic [31:0]               reg_rdata_o,
  output logic                      eng_start_o,
  input  logic                      eng_done_i,
  input  logic [N_WORDS*DATA_W-1:0] eng_data_i,
  input  logic [AW-1:0]             buf_raddr_i,
  output logic [DATA_W-1:0]         buf_rdata_o,
  output logic                      irq_o
);
  logic             en_q;
  logic [PER_W-1:0] period_q;
  logic             tick, ack, we, ovr;
  logic [AW-1:0]    waddr;
  logic [CNT_W-1:0] skip;
  logic [DATA_W-1:0] wdata;
  seq_state_e       state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      period_q <= PER_W'(DEF_PERIOD);
    end else if (reg_we_i) begin
      if (reg_addr_i == A_CTRL)   en_q     <= reg_wdata_i[0];
      if (reg_addr_i == A_PERIOD) period_q <= reg_wdata_i[PER_W-1:0];
    end
  end

  assign ack   = reg_we_i && (reg_addr_i == A_ACK);
  assign wdata = eng_data_i[int'(waddr)*DATA_W +: DATA_W];

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:   reg_rdata_o = {31'b0, en_q};
      A_PERIOD: reg_rdata_o = 32'(period_q);
      A_STATUS: reg_rdata_o = {28'b0, irq_o, ovr, 2'(state)};
      A_SKIP:   reg_rdata_o = 32'(skip);
      default:  reg_rdata_o = '0;
    endcase
  end

  step_timer #(.PER_W(PER_W)) u_timer (
    .clk_i, .rst_ni, .en_i(en_q), .period_i(period_q), .tick_o(tick)
  );

  step_seq_fsm #(.N_WORDS(N_WORDS), .CNT_W(CNT_W)) u_fsm (
    .clk_i, .rst_ni, .tick_i(tick), .ack_i(ack), .done_i(eng_done_i),
    .start_o(eng_start_o), .state_o(state), .irq_o(irq_o), .we_o(we),
    .waddr_o(waddr), .skip_o(skip), .overrun_o(ovr)
  );

  step_result_buf #(.DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_buf (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .raddr_i(buf_raddr_i), .rdata_o(buf_rdata_o)
  );

  a_r4_ack_ignored_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack && state == ST_IDLE && !tick |=> state == ST_IDLE);
endmodule

// File: tb/step_pacer_tb.sv
module step_pacer_tb_top;
  localparam int CLK_P   = 10;
  localparam int DATA_W  = 32;
  localparam int N_WORDS = 8;
  localparam int AW      = $clog2(N_WORDS);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic eng_start, eng_done = 1'b0, irq;
  logic [N_WORDS*DATA_W-1:0] eng_data = '0;
  logic [AW-1:0] buf_raddr = '0;
  logic [DATA_W-1:0] buf_rdata;

  int checks = 0, errors = 0;
  int cyc = 0, n_starts = 0, last_start = 0, prev_start = 0;
  int done_cyc = 0, irq_rise = 0, wr_cyc = 0, max_start_w = 0, start_w = 0;
  int eng_lat = 10;
  logic irq_prev = 1'b0;
  logic [31:0] exp_words [N_WORDS];

  always #(CLK_P/2) clk = ~clk;

  step_pacer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .eng_start_o(eng_start),
    .eng_done_i(eng_done), .eng_data_i(eng_data), .buf_raddr_i(buf_raddr),
    .buf_rdata_o(buf_rdata), .irq_o(irq)
  );

  function automatic logic [31:0] exp_status(int st, bit ovr, bit irq_b);
    return {28'b0, irq_b, ovr, 2'(st)};
  endfunction

  function automatic logic [31:0] gen_word();
    int sel = $urandom_range(0, 5);
    if (sel == 0) return 32'h8000_0000;
    if (sel == 1) return 32'h7fff_ffff;
    return $urandom();
  endfunction

  // monitor, just after each rising edge
  always @(posedge clk) begin
    cyc++;
    #1;
    if (eng_start) begin
      n_starts++; prev_start = last_start; last_start = cyc; start_w++;
      if (start_w > max_start_w) max_start_w = start_w;
    end else start_w = 0;
    if (irq && !irq_prev) irq_rise = cyc;
    irq_prev = irq;
  end

  // engine stand-in with programmable latency
  always @(negedge clk) begin
    if (eng_start) begin
      for (int i = 0; i < N_WORDS; i++) begin
        exp_words[i] = gen_word();
        eng_data[i*DATA_W +: DATA_W] = exp_words[i];
      end
      repeat (eng_lat - 1) @(negedge clk);
      eng_done = 1'b1; done_cyc = cyc;
      @(negedge clk);
      eng_done = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; wr_cyc = cyc;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic buf_read(input int i, output logic [31:0] d);
    @(negedge clk); buf_raddr = AW'(i);
    @(negedge clk); d = buf_rdata;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
  endtask

  task automatic wait_start(input int n0);
    for (int i = 0; i < 5000 && n_starts == n0; i++) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R10 watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d, s0;
    int per, n0, e_cyc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R10 / R8 reset state
    reg_read(3'd2, d); chk("R10 status", d, exp_status(0, 0, 0));
    chk("R10 irq", 32'(irq), 0);
    chk("R10 start", 32'(eng_start), 0);
    reg_read(3'd4, d); chk("R10 skip", d, 0);
    reg_read(3'd1, d); chk("R1 period reset", d, 300);

    // R4 ack ignored in IDLE
    reg_write(3'd3, 1);
    reg_read(3'd2, d); chk("R4 ack idle", d, exp_status(0, 0, 0));

    // R1 R2 R3 R9 random periods and latencies
    eng_lat = $urandom_range(5, 30);
    per = eng_lat + 3*N_WORDS + 30 + $urandom_range(0, 40);
    reg_write(3'd1, per);
    reg_write(3'd0, 1);
    for (int k = 0; k < 4; k++) begin
      wait_irq();
      chk("R3 irq delay", irq_rise - done_cyc, N_WORDS + 1);
      reg_read(3'd2, d); chk("R8 wait_ack status", d, exp_status(3, 0, 1));
      for (int i = 0; i < N_WORDS; i++) begin
        buf_read(i, d); chk("R3 R9 word", d, exp_words[i]);
      end
      if (k > 0) chk("R1 interval", last_start - prev_start, per);
      reg_write(3'd3, 0);
      reg_read(3'd2, d); chk("R4 ack clears", d, exp_status(0, 0, 0));
    end
    chk("R2 start width", max_start_w, 1);
    chk("R2 start count", n_starts, 4);

    // R4 ack during RUN ignored, R8 RUN encoding
    n0 = n_starts;
    wait_start(n0);
    reg_read(3'd2, d); chk("R8 run status", d, exp_status(1, 0, 0));
    reg_write(3'd3, 0);
    wait_irq();
    repeat (20) @(negedge clk);
    chk("R4 irq held", 32'(irq), 1);

    // R5 blocked: exactly 3 ticks in 3*per edges
    n0 = n_starts;
    reg_read(3'd4, s0);
    repeat (3*per - 1) @(negedge clk);
    reg_read(3'd4, d); chk("R5 skip delta", d - s0, 3);
    chk("R5 no start", n_starts, n0);

    // R5 tick coincident with ack, then R6 overrun
    reg_write(3'd0, 0);
    reg_write(3'd1, 1);
    reg_read(3'd4, s0);
    reg_write(3'd0, 1); e_cyc = wr_cyc;
    repeat ($urandom_range(3, 10)) @(negedge clk);
    n0 = n_starts;
    reg_write(3'd3, 0);
    reg_read(3'd4, d); chk("R5 coincident skip", d - s0, wr_cyc - e_cyc);
    chk("R5 start after ack", last_start, wr_cyc + 1);
    chk("R5 one start", n_starts, n0 + 1);
    wait_irq();
    chk("R6 dropped ticks", n_starts, n0 + 1);
    reg_read(3'd2, d); chk("R6 overrun flag", d, exp_status(3, 1, 1));

    // R5 saturation
    repeat (66000) @(negedge clk);
    reg_read(3'd4, d); chk("R5 saturate", d, 65535);

    // R7 enable clear while pending, then mid-step
    n0 = n_starts;
    reg_write(3'd0, 0);
    reg_write(3'd3, 0);
    repeat (100) @(negedge clk);
    chk("R7 no start", n_starts, n0);
    reg_read(3'd2, d); chk("R7 idle", d, exp_status(0, 1, 0));
    eng_lat = 20;
    reg_write(3'd1, 60);
    reg_write(3'd0, 1);
    wait_start(n0);
    reg_write(3'd0, 0);
    wait_irq();
    chk("R7 step completes", 32'(irq), 1);
    reg_write(3'd3, 0);
    repeat (200) @(negedge clk);
    chk("R7 no restart", n_starts, n0 + 1);
    reg_read(3'd2, d); chk("R7 rests idle", d, exp_status(0, 1, 0));

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule